// File: doc/BRIEF.md
# Interleaved TCM Bank Arbiter

This block sits between three requesters and a pair of 64-bit tightly coupled memory banks. The requesters are a load/store port, an instruction-fetch port that only reads, and a DMA port. Consecutive doublewords alternate between the two banks. Two requesters that walk sequential addresses therefore settle onto opposite banks after a single clash, and from then on both run at full rate.

In every cycle, each bank picks at most one winner by fixed priority. Load/store beats fetch, and fetch beats DMA. A DMA request that keeps losing is promoted after a bounded number of cycles. The winner's grant is combinational, so the bank is driven in the same cycle. Read data, the bank's error flag and a per-byte parity fault vector reach the winning requester two cycles after its grant.

Parity is one bit per data byte. The write path generates it and the read path checks it. A pin selects odd or even sense, and parity checking is enabled separately for each bank. Each bank has its own wait input, which holds off grants to that bank.

Top module: `tcm_ilv_arb`

## Requirements
- R1: All three address ports carry doubleword addresses. Bit 0 selects the bank (0 selects bank 0, 1 selects bank 1). Bits AW-1..1 drive that bank's index output unchanged.
- R2: When the load/store port and another requester want the same bank, the load/store port is granted and the other is not, unless the DMA promotion of R4 is active.
- R3: When fetch and DMA want a bank that the load/store port is not using, fetch is granted and DMA is not.
- R4: A DMA request that first loses in cycle t is granted no later than cycle t+2, provided its bank's wait is low. Once promoted, it wins over both other requesters.
- R5: Requesters on different banks are granted in the same cycle, and each receives its own read data.
- R6: While a bank's wait input is high, that bank grants nobody and its enable stays low. The other bank is unaffected. A held requester is granted once the wait drops.
- R7: A read granted in cycle t returns rvalid and the read data in cycle t+2, and in no other cycle.
- R8: The bank's error input, sampled in the cycle after the grant, is returned on the winning requester's err output together with its read data.
- R9: Write parity bit i equals the XOR of data byte i, inverted when the odd-sense pin is 1. The result is that data plus parity carries an odd number of ones when the pin is 1, and an even number when it is 0.
- R10: On reads, pfault bit i is set when byte i and its parity bit disagree with the selected sense, but only if the checking-enable bit of the bank that served the read is set. Otherwise the vector is zero.
- R11: For writes, the byte-enable bits are passed to the bank in place, with bit i covering data byte i and parity bit i. For reads, the byte-enable output is all zero. Bytes that are not enabled keep their earlier contents.
- R12: While reset is asserted, no grant or bank enable is issued, even with requests present, and all rvalid outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| odd_par | input | 1 | Parity sense: 1 odd, 0 even |
| chk_en | input | 2 | Per-bank parity check enable |
| ls_req | input | 1 | Load/store request |
| ls_we | input | 1 | Load/store write |
| ls_addr | input | AW | Load/store doubleword address |
| ls_wdata | input | 64 | Load/store write data |
| ls_be | input | 8 | Load/store byte enables |
| ls_gnt | output | 1 | Load/store granted this cycle |
| ls_rvalid | output | 1 | Load/store read response valid |
| ls_rdata | output | 64 | Load/store read data |
| ls_err | output | 1 | Load/store bank error |
| ls_pfault | output | 8 | Load/store per-byte parity fault |
| fe_req | input | 1 | Fetch request (read only) |
| fe_addr | input | AW | Fetch doubleword address |
| fe_gnt | output | 1 | Fetch granted |
| fe_rvalid | output | 1 | Fetch response valid |
| fe_rdata | output | 64 | Fetch read data |
| fe_err | output | 1 | Fetch bank error |
| fe_pfault | output | 8 | Fetch parity fault |
| dm_req | input | 1 | DMA request |
| dm_we | input | 1 | DMA write |
| dm_addr | input | AW | DMA doubleword address |
| dm_wdata | input | 64 | DMA write data |
| dm_be | input | 8 | DMA byte enables |
| dm_gnt | output | 1 | DMA granted |
| dm_rvalid | output | 1 | DMA response valid |
| dm_rdata | output | 64 | DMA read data |
| dm_err | output | 1 | DMA bank error |
| dm_pfault | output | 8 | DMA parity fault |
| bk_en | output | 2 | Per-bank access enable |
| bk_we | output | 2 | Per-bank write |
| bk_idx | output | 2 x (AW-1) | Per-bank doubleword index |
| bk_wdata | output | 2 x 64 | Per-bank write data |
| bk_wpar | output | 2 x 8 | Per-bank write parity |
| bk_be | output | 2 x 8 | Per-bank byte enables |
| bk_rdata | input | 2 x 64 | Per-bank read data, one cycle after enable |
| bk_rpar | input | 2 x 8 | Per-bank read parity |
| bk_wait | input | 2 | Per-bank wait |
| bk_err | input | 2 | Per-bank error, with read data |

## Verification
Arbitration and response return overlap in time. A requester can be granted on one bank in the same cycle that an earlier read from the other bank is delivered to it or to another requester. A clash on one bank can also coincide with a free grant on the other. The bench provokes this by issuing simultaneous load/store and DMA reads to opposite banks, by holding one bank in wait while fetch proceeds on the other, and by injecting an error on one bank while the other bank returns clean data. Each response is judged by its owner, its arrival cycle and its data, error and fault fields, which the bench compares against its own memory model and its own parity computation.

// File: rtl/tcm_arb_pkg.sv
package tcm_arb_pkg;
  localparam int DW    = 64;
  localparam int NBY   = DW / 8;
  localparam int NBANK = 2;
  localparam int NREQ  = 3;
  localparam int REQ_LS = 0;
  localparam int REQ_FE = 1;
  localparam int REQ_DM = 2;

  typedef struct packed {
    logic            v;
    logic            we;
    logic [NREQ-1:0] own;
  } slot_t;

  // one parity bit per byte; odd=1 makes data+parity odd-weighted
  function automatic logic [NBY-1:0] par_gen(input logic [DW-1:0] d, input logic odd);
    logic [NBY-1:0] p;
    for (int i = 0; i < NBY; i++) p[i] = (^d[8*i +: 8]) ^ odd;
    return p;
  endfunction

  function automatic logic [NBY-1:0] par_chk(input logic [DW-1:0] d,
                                             input logic [NBY-1:0] p, input logic odd);
    return par_gen(d, odd) ^ p;
  endfunction
endpackage

// File: rtl/tcm_bank_sel.sv
module tcm_bank_sel
  import tcm_arb_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NREQ-1:0] want_i,
  input  logic            boost_i,
  input  logic            stall_i,
  output logic [NREQ-1:0] own_o
);
  always_comb begin
    own_o = '0;
    if (!stall_i) begin
      if (want_i[REQ_DM] && boost_i)  own_o[REQ_DM] = 1'b1;
      else if (want_i[REQ_LS])        own_o[REQ_LS] = 1'b1;
      else if (want_i[REQ_FE])        own_o[REQ_FE] = 1'b1;
      else if (want_i[REQ_DM])        own_o[REQ_DM] = 1'b1;
    end
  end

  a_r2_single_owner: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(own_o));
  a_r6_stall_idle: assert property (@(posedge clk) disable iff (!rst_n)
    stall_i |-> (own_o == '0));
  a_r3_fetch_before_dma: assert property (@(posedge clk) disable iff (!rst_n)
    (want_i[REQ_FE] && !want_i[REQ_LS] && !boost_i && !stall_i) |-> !own_o[REQ_DM]);
endmodule

// File: rtl/tcm_resp.sv
module tcm_resp
  import tcm_arb_pkg::*;
(
  input  logic                       clk,
  input  logic                       rst_n,
  input  slot_t [NBANK-1:0]          slot_i,
  input  logic  [NBANK-1:0][DW-1:0]  rdata_i,
  input  logic  [NBANK-1:0][NBY-1:0] rpar_i,
  input  logic  [NBANK-1:0]          err_i,
  input  logic  [NBANK-1:0]          chk_en_i,
  input  logic                       odd_i,
  output logic  [NREQ-1:0]           rv_o,
  output logic  [NREQ-1:0][DW-1:0]   rd_o,
  output logic  [NREQ-1:0]           er_o,
  output logic  [NREQ-1:0][NBY-1:0]  pf_o
);
  logic [NBANK-1:0][NBY-1:0] flt;

  always_comb begin
    for (int b = 0; b < NBANK; b++)
      flt[b] = chk_en_i[b] ? par_chk(rdata_i[b], rpar_i[b], odd_i) : '0;
  end

  for (genvar r = 0; r < NREQ; r++) begin : g_req
    logic [NBANK-1:0] hit;
    logic             rv_q, er_q;
    logic [DW-1:0]    rd_q;
    logic [NBY-1:0]   pf_q;

    always_comb begin
      for (int b = 0; b < NBANK; b++)
        hit[b] = slot_i[b].v && !slot_i[b].we && slot_i[b].own[r];
    end

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        rv_q <= 1'b0; er_q <= 1'b0; rd_q <= '0; pf_q <= '0;
      end else begin
        rv_q <= |hit;
        er_q <= 1'b0; rd_q <= '0; pf_q <= '0;
        for (int b = 0; b < NBANK; b++) begin
          if (hit[b]) begin
            er_q <= err_i[b]; rd_q <= rdata_i[b]; pf_q <= flt[b];
          end
        end
      end
    end

    assign rv_o[r] = rv_q;
    assign rd_o[r] = rd_q;
    assign er_o[r] = er_q;
    assign pf_o[r] = pf_q;

    // R5: one requester is never served by both banks in one cycle
    a_r5_one_source: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(hit));
  end
endmodule

// File: rtl/tcm_ilv_arb.sv
module tcm_ilv_arb
  import tcm_arb_pkg::*;
#(
  parameter  int AW      = 7,
  parameter  int DMA_AGE = 2,
  localparam int IW      = AW - 1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       odd_par,
  input  logic [NBANK-1:0]           chk_en,
  input  logic                       ls_req,
  input  logic                       ls_we,
  input  logic [AW-1:0]              ls_addr,
  input  logic [DW-1:0]              ls_wdata,
  input  logic [NBY-1:0]             ls_be,
  output logic                       ls_gnt,
  output logic                       ls_rvalid,
  output logic [DW-1:0]              ls_rdata,
  output logic                       ls_err,
  output logic [NBY-1:0]             ls_pfault,
  input  logic                       fe_req,
  input  logic [AW-1:0]              fe_addr,
  output logic                       fe_gnt,
  output logic                       fe_rvalid,
  output logic [DW-1:0]              fe_rdata,
  output logic                       fe_err,
  output logic [NBY-1:0]             fe_pfault,
  input  logic                       dm_req,
  input  logic                       dm_we,
  input  logic [AW-1:0]              dm_addr,
  input  logic [DW-1:0]              dm_wdata,
  input  logic [NBY-1:0]             dm_be,
  output logic                       dm_gnt,
  output logic                       dm_rvalid,
  output logic [DW-1:0]              dm_rdata,
  output logic                       dm_err,
  output logic [NBY-1:0]             dm_pfault,
  output logic [NBANK-1:0]           bk_en,
  output logic [NBANK-1:0]           bk_we,
  output logic [NBANK-1:0][IW-1:0]   bk_idx,
  output logic [NBANK-1:0][DW-1:0]   bk_wdata,
  output logic [NBANK-1:0][NBY-1:0]  bk_wpar,
  output logic [NBANK-1:0][NBY-1:0]  bk_be,
  input  logic [NBANK-1:0][DW-1:0]   bk_rdata,
  input  logic [NBANK-1:0][NBY-1:0]  bk_rpar,
  input  logic [NBANK-1:0]           bk_wait,
  input  logic [NBANK-1:0]           bk_err
);
  localparam int CW = $clog2(DMA_AGE + 1);

  logic [NREQ-1:0]                rq, wr, gnt;
  logic [NREQ-1:0][AW-1:0]        ad;
  logic [NREQ-1:0][DW-1:0]        wd;
  logic [NREQ-1:0][NBY-1:0]       wbe;
  logic [NBANK-1:0][NREQ-1:0]     own;
  slot_t [NBANK-1:0]              slot;
  logic [CW-1:0]                  dm_age;
  logic                           dm_boost;
  logic [NREQ-1:0]                rv, er;
  logic [NREQ-1:0][DW-1:0]        rd;
  logic [NREQ-1:0][NBY-1:0]       pf;

  assign rq  = {dm_req, fe_req, ls_req};
  assign wr  = {dm_we, 1'b0, ls_we};
  assign ad  = {dm_addr, fe_addr, ls_addr};
  assign wd  = {dm_wdata, {DW{1'b0}}, ls_wdata};
  assign wbe = {dm_be, {NBY{1'b0}}, ls_be};

  assign dm_boost = (dm_age >= CW'(DMA_AGE));

  always_comb begin
    gnt = '0;
    for (int b = 0; b < NBANK; b++) gnt = gnt | own[b];
  end

  // consecutive DMA losses; saturates at the promotion threshold
  always_ff @(posedge clk) begin
    if (!rst_n)                      dm_age <= '0;
    else if (!dm_req || gnt[REQ_DM]) dm_age <= '0;
    else if (!dm_boost)              dm_age <= dm_age + 1'b1;
  end

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    logic [NREQ-1:0] want;
    logic [IW-1:0]   s_idx;
    logic [DW-1:0]   s_wd;
    logic [NBY-1:0]  s_be;
    logic            s_we;
    slot_t           slot_q;

    always_comb begin
      for (int r = 0; r < NREQ; r++) want[r] = rq[r] && (ad[r][0] == 1'(b));
    end

    tcm_bank_sel u_sel (
      .clk     (clk),
      .rst_n   (rst_n),
      .want_i  (want),
      .boost_i (dm_boost),
      .stall_i (bk_wait[b] || !rst_n),
      .own_o   (own[b])
    );

    always_comb begin
      s_idx = '0; s_wd = '0; s_be = '0; s_we = 1'b0;
      for (int r = 0; r < NREQ; r++) begin
        if (own[b][r]) begin
          s_idx = ad[r][AW-1:1]; s_wd = wd[r]; s_be = wbe[r]; s_we = wr[r];
        end
      end
    end

    assign bk_en[b]    = |own[b];
    assign bk_we[b]    = s_we;
    assign bk_idx[b]   = s_idx;
    assign bk_wdata[b] = s_wd;
    assign bk_wpar[b]  = s_we ? par_gen(s_wd, odd_par) : '0;
    assign bk_be[b]    = s_we ? s_be : '0;

    always_ff @(posedge clk) begin
      if (!rst_n) slot_q <= '0;
      else        slot_q <= '{v: bk_en[b], we: s_we, own: own[b]};
    end
    assign slot[b] = slot_q;

    a_r6_wait_no_enable: assert property (@(posedge clk) disable iff (!rst_n)
      bk_wait[b] |-> !bk_en[b]);
  end

  tcm_resp u_resp (
    .clk      (clk),
    .rst_n    (rst_n),
    .slot_i   (slot),
    .rdata_i  (bk_rdata),
    .rpar_i   (bk_rpar),
    .err_i    (bk_err),
    .chk_en_i (chk_en),
    .odd_i    (odd_par),
    .rv_o     (rv),
    .rd_o     (rd),
    .er_o     (er),
    .pf_o     (pf)
  );

  assign ls_gnt = gnt[REQ_LS];
  assign fe_gnt = gnt[REQ_FE];
  assign dm_gnt = gnt[REQ_DM];
  assign ls_rvalid = rv[REQ_LS]; assign ls_rdata = rd[REQ_LS];
  assign ls_err    = er[REQ_LS]; assign ls_pfault = pf[REQ_LS];
  assign fe_rvalid = rv[REQ_FE]; assign fe_rdata = rd[REQ_FE];
  assign fe_err    = er[REQ_FE]; assign fe_pfault = pf[REQ_FE];
  assign dm_rvalid = rv[REQ_DM]; assign dm_rdata = rd[REQ_DM];
  assign dm_err    = er[REQ_DM]; assign dm_pfault = pf[REQ_DM];

  a_r1_route: assert property (@(posedge clk) disable iff (!rst_n)
    ls_gnt |-> (bk_en[ls_addr[0]] && bk_idx[ls_addr[0]] == ls_addr[AW-1:1]));
  a_r2_ls_served: assert property (@(posedge clk) disable iff (!rst_n)
    (ls_req && !bk_wait[ls_addr[0]] && !(dm_boost && dm_req && dm_addr[0] == ls_addr[0]))
      |-> ls_gnt);
  a_r4_dma_promoted: assert property (@(posedge clk) disable iff (!rst_n)
    (dm_boost && dm_req && !bk_wait[dm_addr[0]]) |-> dm_gnt);
  a_r7_ls_latency: assert property (@(posedge clk) disable iff (!rst_n)
    (ls_gnt && !ls_we) |-> ##2 ls_rvalid);
endmodule

// File: tb/tcm_ilv_arb_tb.sv
module tcm_ilv_arb_tb;
  localparam int AW = 7;
  localparam int IW = AW - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic odd_par;
  logic [1:0] chk_en;
  logic ls_req, ls_we, ls_gnt, ls_rvalid, ls_err;
  logic [AW-1:0] ls_addr;
  logic [63:0] ls_wdata, ls_rdata;
  logic [7:0] ls_be, ls_pfault;
  logic fe_req, fe_gnt, fe_rvalid, fe_err;
  logic [AW-1:0] fe_addr;
  logic [63:0] fe_rdata;
  logic [7:0] fe_pfault;
  logic dm_req, dm_we, dm_gnt, dm_rvalid, dm_err;
  logic [AW-1:0] dm_addr;
  logic [63:0] dm_wdata, dm_rdata;
  logic [7:0] dm_be, dm_pfault;
  logic [1:0] bk_en, bk_we, bk_wait, bk_err;
  logic [1:0][IW-1:0] bk_idx;
  logic [1:0][63:0] bk_wdata, bk_rdata;
  logic [1:0][7:0] bk_wpar, bk_be, bk_rpar;

  logic [63:0] mem  [2][64];
  logic [7:0]  mpar [2][64];
  logic [1:0][63:0] rdq, corrupt;
  logic [1:0][7:0]  rpq;
  logic [1:0] erq, err_inj;

  int n_chk = 0;
  int n_fail = 0;
  logic done = 1'b0;

  tcm_ilv_arb #(.AW(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .odd_par(odd_par), .chk_en(chk_en),
    .ls_req(ls_req), .ls_we(ls_we), .ls_addr(ls_addr), .ls_wdata(ls_wdata), .ls_be(ls_be),
    .ls_gnt(ls_gnt), .ls_rvalid(ls_rvalid), .ls_rdata(ls_rdata), .ls_err(ls_err),
    .ls_pfault(ls_pfault),
    .fe_req(fe_req), .fe_addr(fe_addr), .fe_gnt(fe_gnt), .fe_rvalid(fe_rvalid),
    .fe_rdata(fe_rdata), .fe_err(fe_err), .fe_pfault(fe_pfault),
    .dm_req(dm_req), .dm_we(dm_we), .dm_addr(dm_addr), .dm_wdata(dm_wdata), .dm_be(dm_be),
    .dm_gnt(dm_gnt), .dm_rvalid(dm_rvalid), .dm_rdata(dm_rdata), .dm_err(dm_err),
    .dm_pfault(dm_pfault),
    .bk_en(bk_en), .bk_we(bk_we), .bk_idx(bk_idx), .bk_wdata(bk_wdata), .bk_wpar(bk_wpar),
    .bk_be(bk_be), .bk_rdata(bk_rdata), .bk_rpar(bk_rpar), .bk_wait(bk_wait), .bk_err(bk_err)
  );

  // behavioural banks: one-cycle read, byte-enabled write
  always @(posedge clk) begin
    for (int b = 0; b < 2; b++) begin
      if (bk_en[b]) begin
        if (bk_we[b]) begin
          for (int i = 0; i < 8; i++) begin
            if (bk_be[b][i]) begin
              mem[b][bk_idx[b]][8*i +: 8] <= bk_wdata[b][8*i +: 8];
              mpar[b][bk_idx[b]][i]       <= bk_wpar[b][i];
            end
          end
        end else begin
          rdq[b] <= mem[b][bk_idx[b]];
          rpq[b] <= mpar[b][bk_idx[b]];
          erq[b] <= err_inj[b];
        end
      end
    end
  end
  assign bk_rdata = {rdq[1] ^ corrupt[1], rdq[0] ^ corrupt[0]};
  assign bk_rpar  = rpq;
  assign bk_err   = erq;

  function automatic logic [7:0] exp_par(logic [63:0] d, logic odd);
    logic [7:0] p;
    for (int i = 0; i < 8; i++) p[i] = ($countones(d[8*i +: 8]) % 2 == 0) ? odd : !odd;
    return p;
  endfunction

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle();
    ls_req = 0; ls_we = 0; ls_addr = '0; ls_wdata = '0; ls_be = '0;
    fe_req = 0; fe_addr = '0;
    dm_req = 0; dm_we = 0; dm_addr = '0; dm_wdata = '0; dm_be = '0;
  endtask

  task automatic flush();
    idle();
    repeat (3) @(negedge clk);
  endtask

  task automatic ls_write(logic [AW-1:0] a, logic [63:0] d, logic [7:0] be);
    @(negedge clk);
    ls_req = 1; ls_we = 1; ls_addr = a; ls_wdata = d; ls_be = be;
    #1 chk("R11 write byte enables passed", 64'(bk_be[a[0]]), 64'(be));
    @(negedge clk);
    idle();
  endtask

  task automatic ls_read(logic [AW-1:0] a, string tag, logic [63:0] exp);
    @(negedge clk);
    ls_req = 1; ls_we = 0; ls_addr = a;
    #1 chk({tag, " grant"}, 64'(ls_gnt), 64'd1);
    @(negedge clk);
    idle();
    #1 chk("R7 no early rvalid", 64'(ls_rvalid), 64'd0);
    @(negedge clk);
    #1 chk("R7 rvalid at grant+2", 64'(ls_rvalid), 64'd1);
    chk({tag, " data"}, ls_rdata, exp);
  endtask

  task automatic t_reset();
    ls_req = 1; ls_addr = 7'd2; fe_req = 1; fe_addr = 7'd3;
    repeat (2) @(negedge clk);
    #1 chk("R12 no ls grant in reset", 64'(ls_gnt), 64'd0);
    chk("R12 no fe grant in reset", 64'(fe_gnt), 64'd0);
    chk("R12 no bank enable in reset", 64'(bk_en), 64'd0);
    chk("R12 no rvalid in reset", 64'({ls_rvalid, fe_rvalid, dm_rvalid}), 64'd0);
    idle();
    @(negedge clk) rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_route();
    @(negedge clk);
    ls_req = 1; ls_addr = 7'd5;
    #1 chk("R1 odd address enables bank1", 64'(bk_en), 64'b10);
    chk("R1 bank1 index", 64'(bk_idx[1]), 64'd2);
    @(negedge clk);
    ls_addr = 7'd4;
    #1 chk("R1 even address enables bank0", 64'(bk_en), 64'b01);
    chk("R1 bank0 index", 64'(bk_idx[0]), 64'd2);
    flush();
  endtask

  task automatic t_wr_rd();
    logic [63:0] d1, d2;
    d1 = 64'h0123_4567_89AB_CDEF;
    d2 = 64'h0F00_0300_0100_FFFF;
    odd_par = 1;
    @(negedge clk);
    ls_req = 1; ls_we = 1; ls_addr = 7'd6; ls_wdata = d1; ls_be = 8'hFF;
    #1 chk("R9 odd parity generated", 64'(bk_wpar[0]), 64'(exp_par(d1, 1'b1)));
    @(negedge clk);
    odd_par = 0; ls_addr = 7'd7; ls_wdata = d2;
    #1 chk("R9 even parity generated", 64'(bk_wpar[1]), 64'(exp_par(d2, 1'b0)));
    @(negedge clk);
    idle(); odd_par = 1;
    ls_read(7'd6, "R7 read back", d1);
    flush();
  endtask

  task automatic t_bytes();
    odd_par = 1; chk_en = 2'b11;
    ls_write(7'd8, 64'hFFFF_FFFF_FFFF_FFFF, 8'hFF);
    ls_write(7'd8, 64'h0, 8'h0F);
    ls_read(7'd8, "R11 partial write", 64'hFFFF_FFFF_0000_0000);
    chk("R10 no fault on partially written word", 64'(ls_pfault), 64'd0);
    chk_en = 2'b00;
    flush();
  endtask

  task automatic t_ls_prio();
    @(negedge clk);
    ls_req = 1; ls_addr = 7'd10; fe_req = 1; fe_addr = 7'd12; dm_req = 1; dm_addr = 7'd14;
    #1 chk("R2 ls wins bank", 64'(ls_gnt), 64'd1);
    chk("R2 fe loses to ls", 64'(fe_gnt), 64'd0);
    chk("R2 dm loses to ls", 64'(dm_gnt), 64'd0);
    flush();
  endtask

  task automatic t_fe_dm();
    @(negedge clk);
    ls_req = 1; ls_addr = 7'd10; fe_req = 1; fe_addr = 7'd13; dm_req = 1; dm_addr = 7'd15;
    #1 chk("R3 fe wins free bank", 64'(fe_gnt), 64'd1);
    chk("R3 dm loses to fe", 64'(dm_gnt), 64'd0);
    chk("R5 ls granted on other bank", 64'(ls_gnt), 64'd1);
    flush();
  endtask

  task automatic t_dma_age();
    @(negedge clk);
    ls_req = 1; ls_addr = 7'd2; dm_req = 1; dm_addr = 7'd4;
    #1 chk("R2 dm stalls on clash", 64'(dm_gnt), 64'd0);
    @(negedge clk);
    #1 chk("R4 dm still held t+1", 64'(dm_gnt), 64'd0);
    @(negedge clk);
    #1 chk("R4 dm granted by t+2", 64'(dm_gnt), 64'd1);
    chk("R4 promoted dm beats ls", 64'(ls_gnt), 64'd0);
    @(negedge clk);
    dm_req = 0;
    #1 chk("R2 ls resumes", 64'(ls_gnt), 64'd1);
    @(negedge clk);
    #1 chk("R7 dm rvalid two cycles after grant", 64'(dm_rvalid), 64'd1);
    flush();
  endtask

  task automatic t_parallel();
    odd_par = 1;
    @(negedge clk);
    ls_req = 1; ls_we = 1; ls_addr = 7'd20; ls_wdata = 64'hA5A5_0000_1111_2222; ls_be = 8'hFF;
    dm_req = 1; dm_we = 1; dm_addr = 7'd21; dm_wdata = 64'h3C3C_7777_8888_9999; dm_be = 8'hFF;
    #1 chk("R5 ls write granted", 64'(ls_gnt), 64'd1);
    chk("R5 dm write granted same cycle", 64'(dm_gnt), 64'd1);
    @(negedge clk);
    ls_we = 0; dm_we = 0;
    #1 chk("R5 parallel reads granted", 64'({ls_gnt, dm_gnt}), 64'b11);
    @(negedge clk);
    idle();
    @(negedge clk);
    #1 chk("R5 ls data from bank0", ls_rdata, 64'hA5A5_0000_1111_2222);
    chk("R5 dm data from bank1", dm_rdata, 64'h3C3C_7777_8888_9999);
    chk("R5 both valid", 64'({ls_rvalid, dm_rvalid}), 64'b11);
    flush();
  endtask

  task automatic t_wait();
    @(negedge clk);
    bk_wait = 2'b01;
    ls_req = 1; ls_addr = 7'd20; fe_req = 1; fe_addr = 7'd21;
    #1 chk("R6 ls held by wait", 64'(ls_gnt), 64'd0);
    chk("R6 bank0 not enabled", 64'(bk_en[0]), 64'd0);
    chk("R6 fe proceeds on bank1", 64'(fe_gnt), 64'd1);
    @(negedge clk);
    fe_req = 0;
    #1 chk("R6 ls still held", 64'(ls_gnt), 64'd0);
    @(negedge clk);
    bk_wait = 2'b00;
    #1 chk("R6 ls granted after wait", 64'(ls_gnt), 64'd1);
    @(negedge clk);
    idle();
    @(negedge clk);
    #1 chk("R6 held read data", ls_rdata, 64'hA5A5_0000_1111_2222);
    flush();
  endtask

  task automatic t_err();
    err_inj = 2'b10;
    @(negedge clk);
    ls_req = 1; ls_addr = 7'd20; fe_req = 1; fe_addr = 7'd21;
    @(negedge clk);
    idle();
    @(negedge clk);
    #1 chk("R8 fe gets bank1 error", 64'(fe_err), 64'd1);
    chk("R8 ls clean from bank0", 64'(ls_err), 64'd0);
    chk("R8 error with data", fe_rdata, 64'h3C3C_7777_8888_9999);
    err_inj = 2'b00;
    flush();
  endtask

  task automatic t_parity();
    odd_par = 1;
    chk_en = 2'b01;
    corrupt[0] = 64'h0000_0000_0001_0000;
    ls_read(7'd20, "R10 corrupted read", 64'hA5A5_0000_1110_2222);
    chk("R10 byte2 fault flagged", 64'(ls_pfault), 64'h04);
    chk_en = 2'b10;
    ls_read(7'd20, "R10 unchecked read", 64'hA5A5_0000_1110_2222);
    chk("R10 fault suppressed when disabled", 64'(ls_pfault), 64'h00);
    corrupt[0] = '0;
    corrupt[1] = 64'h8000_0000_0000_0000;
    @(negedge clk);
    dm_req = 1; dm_addr = 7'd21;
    @(negedge clk);
    idle();
    @(negedge clk);
    #1 chk("R10 dm byte7 fault", 64'(dm_pfault), 64'h80);
    corrupt = '0; chk_en = 2'b00;
    flush();
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    idle();
    odd_par = 1; chk_en = 2'b00; bk_wait = 2'b00; err_inj = 2'b00; corrupt = '0;
    t_reset();
    t_route();
    t_wr_rd();
    t_bytes();
    t_ls_prio();
    t_fe_dm();
    t_dma_age();
    t_parallel();
    t_wait();
    t_err();
    t_parity();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule